// File: doc/BRIEF.md
# Clock-Recovery Acquisition Mode Controller

This block decides how a clock-and-data-recovery loop acquires and holds lock. After reset, or while the receive path reports that its serial input is missing, it keeps the loop in reference-lock mode. In that mode the frequency detector trains the oscillator. The block measures the recovered clock against the reference clock throughout. It counts rising edges of a divided copy of the recovered clock over a fixed window of reference cycles. It then checks whether that count lies within a ppm tolerance of the expected count.

Two in-tolerance windows in a row move the loop to data-lock mode. In that mode the bang-bang phase detector drives the loop and the frequency detector is turned off. The measurement keeps running in data-lock mode, and any window outside the tolerance returns the loop to reference-lock mode. Mode changes take effect only when a window closes. The one exception is loss of signal, which forces reference mode on the next clock edge. The analog detectors themselves live outside this block; it only drives their enables.

Top module: `cdr_lock_ctrl`

## Requirements
- R1: After reset the controller is in reference mode: data_mode=0, fd_en=1, pd_en=0, locked=0.
- R2: A measurement window lasts 2^WIN_LOG2 clk cycles and counts the rising edges of vco_div, which are found after a SYNC_STAGES-flop synchronizer. A window is in tolerance when the count lies within EXP_COUNT±TOL, where TOL=floor(EXP_COUNT*PPM/1e6). A count of EXP_COUNT-TOL-1 or less, or EXP_COUNT+TOL+1 or more, is out of tolerance.
- R3: In reference mode, two consecutive in-tolerance windows switch the controller to data mode. The switch is seen at the clock edge that closes the second window.
- R4: An in-tolerance window followed by an out-of-tolerance window does not enter data mode, and qualification restarts from zero.
- R5: In data mode, an in-tolerance window keeps data mode, including counts exactly at EXP_COUNT±TOL. An out-of-tolerance window returns the controller to reference mode at the edge that closes that window.
- R6: While los=1 the controller enters reference mode on the next clock edge and stays there. Qualification is cleared and windows ending while los=1 do not count.
- R7: Apart from the los override, the mode and the detector enables change only at the clock edge that closes a measurement window.
- R8: In data mode pd_en=1, fd_en=0 and locked=1. In reference mode pd_en=0, fd_en=1 and locked=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all logic runs on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| vco_div | input | 1 | Divided recovered clock, asynchronous to clk, at most a quarter of the clk rate |
| los | input | 1 | Loss of serial input signal, synchronous to clk |
| data_mode | output | 1 | 1 in data-lock mode, 0 in reference-lock mode |
| fd_en | output | 1 | Enable for the frequency detector path |
| pd_en | output | 1 | Enable for the bang-bang phase detector path |
| locked | output | 1 | Lock indicator, high only in data-lock mode |

## Verification
The assertions assume that los is already synchronous to clk. They also assume that vco_div is slow enough for every rising edge to reach the synchronizer output as a separate pulse, so a window never holds more than half its length in edges. The stimulus generates vco_div from a numerically controlled oscillator clocked by clk, with a rate below half the clock rate. Its increments are exact multiples of 2^32 divided by the window length, so a window that sits fully inside one setting holds exactly the chosen edge count. The bench shortens the window and raises PPM so that the tolerance comes out to one count. Frequency steps that land mid-window are judged only after a full clean window has followed them.

// File: rtl/cdr_lock_pkg.sv
// Shared types for the clock-recovery acquisition controller.
package cdr_lock_pkg;

    // Acquisition state: reference mode, reference mode with one good window, data mode
    typedef enum logic [1:0] {
        ST_REF      = 2'd0,
        ST_REF_QUAL = 2'd1,
        ST_DATA     = 2'd2
    } lock_state_e;

endpackage

// File: rtl/cdr_edge_sync.sv
// Brings an asynchronous slow clock into the clk domain and emits a
// one-cycle pulse per rising edge. Assumes the input stays high and low
// for at least two clk cycles each, so no edge is lost.
module cdr_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise_pulse
);

    logic [SYNC_STAGES:0] chain_q;

    // Shift the input through the synchronizer plus one history flop
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[SYNC_STAGES-1:0], sig_in};
    end

    // A rising edge is a settled 1 following a settled 0
    assign rise_pulse = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

endmodule

// File: rtl/cdr_freq_meter.sv
// Counts edge pulses over windows of 2^WIN_LOG2 clk cycles and reports, in
// the last cycle of each window, whether the total is within EXP_COUNT +/- TOL.
// Assumes edge pulses never occur in adjacent cycles.
module cdr_freq_meter #(
    parameter int WIN_LOG2  = 16,
    parameter int EXP_COUNT = 16000,
    parameter int PPM       = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_pulse,
    output logic win_end,
    output logic freq_in
);

    localparam int    CNT_W    = WIN_LOG2 + 1;
    localparam longint TOL_L   = (longint'(EXP_COUNT) * longint'(PPM)) / 64'd1000000;
    localparam int    TOL      = int'(TOL_L);
    localparam int    LO_I     = (EXP_COUNT > TOL) ? EXP_COUNT - TOL : 0;
    localparam int    HI_I     = EXP_COUNT + TOL;
    localparam logic [CNT_W-1:0] LO_C   = CNT_W'(LO_I);
    localparam logic [CNT_W-1:0] HI_C   = CNT_W'(HI_I);
    localparam logic [CNT_W-1:0] HALF_W = CNT_W'(1 << (WIN_LOG2 - 1));

    logic [WIN_LOG2-1:0] win_cnt_q;
    logic [CNT_W-1:0]    edge_cnt_q;
    logic [CNT_W-1:0]    total;

    // Free-running window timer; the window closes when it is all ones
    always_ff @(posedge clk) begin
        if (!rst_n) win_cnt_q <= '0;
        else        win_cnt_q <= win_cnt_q + 1'b1;
    end

    assign win_end = &win_cnt_q;

    // Edge accumulator, restarted at every window close
    always_ff @(posedge clk) begin
        if (!rst_n)       edge_cnt_q <= '0;
        else if (win_end) edge_cnt_q <= '0;
        else if (edge_pulse) edge_cnt_q <= edge_cnt_q + 1'b1;
    end

    // Window total includes an edge landing in the closing cycle
    assign total   = edge_cnt_q + {{(CNT_W-1){1'b0}}, edge_pulse};
    assign freq_in = (total >= LO_C) && (total <= HI_C);

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        edge_cnt_q <= HALF_W); // R2

endmodule

// File: rtl/cdr_mode_fsm.sv
// Acquisition state machine. Consumes the window verdicts and the loss of
// signal flag and drives the mode and detector enables. Assumes los is
// synchronous to clk and freq_in is meaningful only when win_end is high.
module cdr_mode_fsm
    import cdr_lock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic win_end,
    input  logic freq_in,
    input  logic los,
    output logic data_mode,
    output logic fd_en,
    output logic pd_en,
    output logic locked
);

    lock_state_e state_q, state_d;

    // Next-state rule: los overrides, otherwise decide at window close
    always_comb begin
        state_d = state_q;
        if (los) begin
            state_d = ST_REF;
        end else if (win_end) begin
            case (state_q)
                ST_REF:      state_d = freq_in ? ST_REF_QUAL : ST_REF;
                ST_REF_QUAL: state_d = freq_in ? ST_DATA     : ST_REF;
                ST_DATA:     state_d = freq_in ? ST_DATA     : ST_REF;
                default:     state_d = ST_REF;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_REF;
        else        state_q <= state_d;
    end

    // Detector enables follow the mode
    assign data_mode = (state_q == ST_DATA);
    assign pd_en     = data_mode;
    assign fd_en     = ~data_mode;
    assign locked    = data_mode;

    AST_ENTRY_TWO_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_mode) |-> $past(state_q == ST_REF_QUAL)); // R3

    AST_EXIT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_mode) |-> ($past(los) || $past(win_end && !freq_in))); // R5

    AST_LOS_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        los |=> (state_q == ST_REF)); // R6

    AST_BOUNDARY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(state_q) |-> ($past(win_end) || $past(los))); // R7

endmodule

// File: rtl/cdr_lock_ctrl.sv
// Top of the acquisition controller: synchronizer, frequency meter and
// mode state machine. Assumes vco_div runs below a quarter of the clk rate
// and los is synchronous to clk.
module cdr_lock_ctrl #(
    parameter int WIN_LOG2    = 16,
    parameter int EXP_COUNT   = 16000,
    parameter int PPM         = 250,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vco_div,
    input  logic los,
    output logic data_mode,
    output logic fd_en,
    output logic pd_en,
    output logic locked
);

    logic edge_pulse;
    logic win_end;
    logic freq_in;

    cdr_edge_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .sig_in     (vco_div),
        .rise_pulse (edge_pulse)
    );

    cdr_freq_meter #(
        .WIN_LOG2  (WIN_LOG2),
        .EXP_COUNT (EXP_COUNT),
        .PPM       (PPM)
    ) u_meter (
        .clk        (clk),
        .rst_n      (rst_n),
        .edge_pulse (edge_pulse),
        .win_end    (win_end),
        .freq_in    (freq_in)
    );

    cdr_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_end   (win_end),
        .freq_in   (freq_in),
        .los       (los),
        .data_mode (data_mode),
        .fd_en     (fd_en),
        .pd_en     (pd_en),
        .locked    (locked)
    );

endmodule

// File: tb/cdr_lock_ctrl_test.sv
// Directed bench: vco_div comes from an exact-rate NCO clocked by clk.
module cdr_lock_ctrl_test;

    localparam int W_LOG2 = 12;
    localparam int W      = 1 << W_LOG2;   // 4096-cycle window
    localparam int EXP    = 2000;          // PPM=500 -> tolerance of 1 count

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic los = 1'b0;
    logic vco_div;
    logic data_mode, fd_en, pd_en, locked;

    logic [31:0] phase = '0;
    logic [31:0] inc   = '0;
    int cyc = 0;
    int vectors = 0;
    int fails = 0;

    always #4 clk = ~clk;   // 125 MHz

    // NCO: increment n*2^20 gives exactly n rising edges per 4096 cycles
    always_ff @(posedge clk) phase <= phase + inc;
    assign vco_div = phase[31];

    // Cycle count since reset release; windows close when cyc % W == 0
    always_ff @(posedge clk) if (rst_n) cyc <= cyc + 1;

    cdr_lock_ctrl #(
        .WIN_LOG2    (W_LOG2),
        .EXP_COUNT   (EXP),
        .PPM         (500),
        .SYNC_STAGES (2)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .vco_div   (vco_div),
        .los       (los),
        .data_mode (data_mode),
        .fd_en     (fd_en),
        .pd_en     (pd_en),
        .locked    (locked)
    );

    task automatic check_mode(input logic exp_data, input string req);
        logic [3:0] act, exp;
        act = {data_mode, fd_en, pd_en, locked};
        exp = {exp_data, ~exp_data, exp_data, exp_data};
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at cyc %0d: {data,fd,pd,lock}=%b expected %b", req, cyc, act, exp);
        end
    endtask

    task automatic set_count(input int n);
        inc = 32'(n) << 20;
    endtask

    task automatic to_mid();
        @(negedge clk);
        while (cyc % W != W / 2) @(negedge clk);
    endtask

    task automatic to_boundary();
        @(negedge clk);
        while (cyc % W != 0) @(negedge clk);
    endtask

    task automatic t_reset();
        set_count(EXP);
        rst_n = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_mode(1'b0, "R1 reset");
        @(negedge clk);
        check_mode(1'b0, "R1 after release");
    endtask

    task automatic t_acquire();
        to_mid();
        check_mode(1'b0, "R3 one window insufficient");
        @(negedge clk);
        while (cyc != 2 * W - 1) @(negedge clk);
        check_mode(1'b0, "R7 before closing edge");
        @(negedge clk);
        check_mode(1'b1, "R3 R8 data mode at second close");
    endtask

    task automatic t_edge_keep();
        to_boundary(); set_count(EXP + 1);
        to_mid(); to_mid();
        check_mode(1'b1, "R5 count +TOL keeps data");
        to_boundary(); set_count(EXP - 1);
        to_mid(); to_mid();
        check_mode(1'b1, "R5 count -TOL keeps data");
    endtask

    task automatic t_exit();
        to_boundary(); set_count(EXP + 2);
        to_mid(); to_mid();
        check_mode(1'b0, "R5 count +TOL+1 exits");
    endtask

    task automatic t_no_entry();
        to_boundary(); set_count(EXP - 2);
        to_mid(); to_mid(); to_mid();
        check_mode(1'b0, "R2 count -TOL-1 never qualifies");
    endtask

    task automatic t_chatter();
        for (int i = 0; i < 4; i++) begin
            to_boundary();
            set_count((i % 2 == 0) ? EXP : EXP - 10);
            to_mid();
            check_mode(1'b0, "R4 alternating windows");
        end
        to_boundary(); set_count(EXP);
        to_mid();
        check_mode(1'b0, "R4 restart needs two windows");
        to_mid(); to_mid();
        check_mode(1'b1, "R3 reacquire");
    endtask

    task automatic t_los();
        to_mid();
        los = 1'b1;
        @(negedge clk);
        check_mode(1'b0, "R6 los forces reference");
        to_mid(); to_mid();
        check_mode(1'b0, "R6 held while los");
        los = 1'b0;
        to_mid();
        check_mode(1'b0, "R6 qualification restarted");
        to_mid();
        check_mode(1'b1, "R6 reacquire after release");
    endtask

    initial begin
        t_reset();
        t_acquire();
        t_edge_keep();
        t_exit();
        t_no_entry();
        t_chatter();
        t_los();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired at cyc %0d: got hang, expected completion", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule